// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core for a small load/store instruction subset in which every instruction finishes in one clock cycle. At each active clock edge the core fetches the word that the program counter addresses, decodes it, reads up to two registers, runs the ALU and updates the register file, the data memory and the program counter together. Instruction words and data words sit in two separate internal arrays. Because of this, a fetch and a data access never compete for the same array within a cycle.

The supported operations are register add, subtract, AND, OR and signed set-less-than, plus word load, word store, branch-if-equal and absolute jump. Decoding happens in two levels. A main decoder turns the opcode into control flags and a 2-bit ALU class. A second decoder turns that class, together with the function field for register-format words, into a 3-bit ALU operation code. A loader port fills either array while the core is held in reset. Two read-only peek ports expose one register and one data word, so that the surrounding logic can observe results.

Top module: `scalar_core`

## Requirements
- R1: Synchronous active-high reset sets the program counter to 0 and clears all registers. While reset is held, no instruction writes a register or a data word, and the program counter stays at 0.
- R2: Register-format words (opcode 0, fields rs[25:21], rt[20:16], rd[15:11], funct[5:0]) write rd with rs+rt for funct 100000, rs-rt for 100010, rs AND rt for 100100, rs OR rt for 100101, and 1 or 0 for signed rs<rt for 101010.
- R3: Load (opcode 35) writes rt with the data word at byte address rs + sign-extended offset[15:0]. The word index is address bits [DAW+1:2]. Negative offsets work.
- R4: Store (opcode 43) writes the value of rt to the data word at byte address rs + sign-extended offset. Negative offsets work.
- R5: Branch-if-equal (opcode 4) sets the program counter to PC+4 + (sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. Backward offsets work.
- R6: Jump (opcode 2) sets the program counter to the upper 4 bits of PC+4 joined with index[25:0] << 2.
- R7: Register 0 always reads as zero, and an instruction that targets it leaves it at zero.
- R8: Every instruction other than a branch or jump advances the program counter by 4. The instruction word index is PC bits [IAW+1:2].
- R9: An unknown opcode, or a register-format word with an unknown funct, writes no register and no data word, and it advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update occurs at its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Loader write strobe |
| load_to_data | input | 1 | Loader target: 1 selects the data array, 0 selects the instruction array |
| load_addr | input | LDW | Loader word index |
| load_data | input | 32 | Loader word value |
| peek_reg | input | 5 | Register number to observe |
| peek_reg_val | output | 32 | Value of the observed register |
| peek_addr | input | DAW | Data word index to observe |
| peek_mem_val | output | 32 | Value of the observed data word |
| pc_out | output | 32 | Current program counter |

## Verification
The properties assume that reset is held for at least one edge before execution starts, and that the loader is used only during reset. With that assumption every fetched word comes from a stable instruction array. They also assume that the program counter stays inside the instruction array, so that each fetched word is one the bench wrote. The stimulus meets these conditions: it fills both arrays under reset, its program ends in a branch to itself, and every data address it forms lies inside the data array.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_JMP  = 6'd2;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_LOAD = 6'd35;
    localparam logic [5:0] OP_STOR = 6'd43;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        AOP_AND = 3'b000,
        AOP_OR  = 3'b001,
        AOP_ADD = 3'b010,
        AOP_SUB = 3'b110,
        AOP_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic       dst_is_rd;
        logic       b_is_imm;
        logic       wb_from_mem;
        logic       reg_wr;
        logic       mem_wr;
        logic       is_branch;
        logic       is_jump;
        alu_class_e cls;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.cls = CLS_ADD;
        case (opcode)
            OP_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_wr    = 1'b1;
                ctrl.cls       = CLS_FUNCT;
            end
            OP_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_wr      = 1'b1;
            end
            OP_STOR: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.cls       = CLS_SUB;
            end
            OP_JMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/core_alu_dec.sv
module core_alu_dec
    import core_pkg::*;
(
    input  alu_class_e cls,
    input  logic [5:0] funct,
    output alu_op_e    op,
    output logic       op_ok
);
    always_comb begin
        op    = AOP_ADD;
        op_ok = 1'b1;
        case (cls)
            CLS_ADD: op = AOP_ADD;
            CLS_SUB: op = AOP_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  op = AOP_ADD;
                    FN_SUB:  op = AOP_SUB;
                    FN_AND:  op = AOP_AND;
                    FN_OR:   op = AOP_OR;
                    FN_SLT:  op = AOP_SLT;
                    default: op_ok = 1'b0;
                endcase
            end
            default: op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] diff;
    assign diff = a - b;

    always_comb begin
        case (op)
            AOP_AND: y = a & b;
            AOP_OR:  y = a | b;
            AOP_ADD: y = a + b;
            AOP_SUB: y = diff;
            AOP_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [W-1:0]             wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][W-1:0]    rdata
);
    logic [W-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end
endmodule

// File: rtl/scalar_core.sv
module scalar_core
    import core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_we,
    input  logic            load_to_data,
    input  logic [LDW-1:0]  load_addr,
    input  logic [31:0]     load_data,
    input  logic [4:0]      peek_reg,
    output logic [31:0]     peek_reg_val,
    input  logic [DAW-1:0]  peek_addr,
    output logic [31:0]     peek_mem_val,
    output logic [31:0]     pc_out
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm_ext;
    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_val, ld_val;
    logic [RAW-1:0]  rs_f, rt_f, rd_f, dst;
    ctrl_t           ctrl;
    alu_op_e         aop;
    logic            aop_ok, alu_zero, rf_we, dm_we;
    logic [2:0][RAW-1:0]  rf_ra;
    logic [2:0][XLEN-1:0] rf_rd;

    // fetch
    assign instr    = imem[pc_q[IAW+1:2]];
    assign rs_f     = instr[25:21];
    assign rt_f     = instr[20:16];
    assign rd_f     = instr[15:11];
    assign imm_ext  = sext16(instr[15:0]);

    core_main_dec u_mdec (
        .opcode (instr[31:26]),
        .ctrl   (ctrl)
    );

    core_alu_dec u_adec (
        .cls   (ctrl.cls),
        .funct (instr[5:0]),
        .op    (aop),
        .op_ok (aop_ok)
    );

    assign rf_ra = {peek_reg, rt_f, rs_f};

    core_regfile #(
        .NREGS (1 << RAW),
        .W     (XLEN),
        .NRD   (3)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (dst),
        .wdata (wb_val),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );

    assign rs_val       = rf_rd[0];
    assign rt_val       = rf_rd[1];
    assign peek_reg_val = rf_rd[2];

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    core_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (aop),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory and writeback
    assign ld_val       = dmem[alu_y[DAW+1:2]];
    assign peek_mem_val = dmem[peek_addr];
    assign dst          = ctrl.dst_is_rd ? rd_f : rt_f;
    assign wb_val       = ctrl.wb_from_mem ? ld_val : alu_y;
    assign rf_we        = ctrl.reg_wr & aop_ok & ~rst;
    assign dm_we        = ctrl.mem_wr & ~rst;

    always_ff @(posedge clk) begin
        if (load_we && !load_to_data) imem[load_addr[IAW-1:0]] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (load_we && load_to_data) dmem[load_addr[DAW-1:0]] <= load_data;
        else if (dm_we)              dmem[alu_y[DAW+1:2]]     <= rt_val;
    end

    // next program counter
    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctrl.is_jump)                  pc_d = jmp_target;
        else if (ctrl.is_branch && alu_zero) pc_d = br_target;
        else                               pc_d = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc_out = pc_q;
endmodule

// File: rtl/core_chk.sv
module core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_we,
    input logic        dm_we
);
    logic [5:0] opc;
    logic       known;
    assign opc   = instr[31:26];
    assign known = (opc == 6'd0) || (opc == 6'd2) || (opc == 6'd4) ||
                   (opc == 6'd35) || (opc == 6'd43);

    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == 32'd0));

    a_r1_no_write_in_reset: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we));

    a_r8_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'd4 && opc != 6'd2) |=> (pc == $past(pc) + 32'd4));

    a_r5_not_taken: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

    a_r5_taken: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd4 && rs_val == rt_val) |=>
        (pc == $past(pc) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    a_r6_jump: assert property (@(posedge clk) disable iff (rst)
        (opc == 6'd2) |=>
        (pc == {$past(pc[31:28] + ((pc[27:2] == 26'h3FFFFFF) ? 4'd1 : 4'd0)),
                $past(instr[25:0]), 2'b00}));

    a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    a_r9_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!rf_we && !dm_we));
endmodule

bind scalar_core core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_q),
    .instr  (instr),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .rf_we  (rf_we),
    .dm_we  (dm_we)
);

// File: tb/scalar_core_tb.sv
module scalar_core_tb_top;
    localparam int IAW = 6;
    localparam int DAW = 6;
    localparam int LDW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            load_we = 1'b0;
    logic            load_to_data = 1'b0;
    logic [LDW-1:0]  load_addr = '0;
    logic [31:0]     load_data = '0;
    logic [4:0]      peek_reg = '0;
    logic [31:0]     peek_reg_val;
    logic [DAW-1:0]  peek_addr = '0;
    logic [31:0]     peek_mem_val;
    logic [31:0]     pc_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    scalar_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .load_we      (load_we),
        .load_to_data (load_to_data),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .peek_reg     (peek_reg),
        .peek_reg_val (peek_reg_val),
        .peek_addr    (peek_addr),
        .peek_mem_val (peek_mem_val),
        .pc_out       (pc_out)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {6'd2, idx};
    endfunction

    // kind: 0 register, 1 data word, 2 program counter
    localparam int NEXP = 22;
    localparam logic [49:0] EXP [NEXP] = '{
        {2'd0, 8'd1,  8'd3, 32'd5},          // R3 load base
        {2'd0, 8'd2,  8'd3, 32'd3},          // R3
        {2'd0, 8'd3,  8'd3, 32'hFFFF_FFF0},  // R3
        {2'd0, 8'd4,  8'd3, 32'h0000_00FF},  // R3
        {2'd0, 8'd5,  8'd2, 32'd8},          // R2 add
        {2'd0, 8'd6,  8'd2, 32'hFFFF_FFFE},  // R2 sub negative
        {2'd0, 8'd7,  8'd2, 32'h0000_00F0},  // R2 and
        {2'd0, 8'd8,  8'd2, 32'd7},          // R2 or
        {2'd0, 8'd9,  8'd2, 32'd1},          // R2 slt signed true
        {2'd0, 8'd10, 8'd2, 32'd0},          // R2 slt false
        {2'd1, 8'd4,  8'd4, 32'd8},          // R4 store
        {2'd0, 8'd11, 8'd3, 32'd8},          // R3 load after store
        {2'd0, 8'd12, 8'd3, 32'd3},          // R3 negative offset
        {2'd0, 8'd0,  8'd7, 32'd0},          // R7 r0 write ignored
        {2'd0, 8'd13, 8'd5, 32'd0},          // R5 skipped by taken branch
        {2'd0, 8'd14, 8'd6, 32'd0},          // R6 skipped by jump
        {2'd0, 8'd15, 8'd9, 32'd0},          // R9 no write on unknown op/funct
        {2'd1, 8'd1,  8'd4, 32'd7},          // R4 negative offset store
        {2'd1, 8'd0,  8'd9, 32'd5},          // R9 data untouched
        {2'd1, 8'd5,  8'd9, 32'd0},          // R9 data untouched
        {2'd1, 8'd2,  8'd3, 32'hFFFF_FFF0},  // R3 data preserved
        {2'd2, 8'd0,  8'd5, 32'd96}          // R5 backward branch to self
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] v);
        peek_reg = idx[4:0];
        #1;
        v = peek_reg_val;
    endtask

    task automatic read_mem(input int idx, output logic [31:0] v);
        peek_addr = idx[DAW-1:0];
        #1;
        v = peek_mem_val;
    endtask

    task automatic load_word(input bit to_data, input int a, input logic [31:0] d);
        @(negedge clk);
        load_we      = 1'b1;
        load_to_data = to_data;
        load_addr    = a[LDW-1:0];
        load_data    = d;
        @(negedge clk);
        load_we      = 1'b0;
    endtask

    initial begin
        logic [31:0] prog [25];
        logic [31:0] v;
        prog[0]  = enc_i(6'd35, 0, 1, 16'd0);
        prog[1]  = enc_i(6'd35, 0, 2, 16'd4);
        prog[2]  = enc_i(6'd35, 0, 3, 16'd8);
        prog[3]  = enc_i(6'd35, 0, 4, 16'd12);
        prog[4]  = enc_r(1, 2, 5, 6'b100000);
        prog[5]  = enc_r(2, 1, 6, 6'b100010);
        prog[6]  = enc_r(4, 3, 7, 6'b100100);
        prog[7]  = enc_r(1, 2, 8, 6'b100101);
        prog[8]  = enc_r(3, 1, 9, 6'b101010);
        prog[9]  = enc_r(1, 3, 10, 6'b101010);
        prog[10] = enc_i(6'd43, 0, 5, 16'd16);
        prog[11] = enc_i(6'd35, 5, 11, 16'd8);
        prog[12] = enc_i(6'd35, 5, 12, 16'hFFFC);
        prog[13] = enc_r(1, 2, 0, 6'b100000);
        prog[14] = enc_i(6'd4, 1, 2, 16'd5);
        prog[15] = enc_i(6'd4, 2, 12, 16'd2);
        prog[16] = enc_r(1, 1, 13, 6'b100000);
        prog[17] = enc_r(2, 2, 13, 6'b100000);
        prog[18] = enc_j(26'd21);
        prog[19] = enc_r(1, 1, 14, 6'b100000);
        prog[20] = enc_r(2, 2, 14, 6'b100000);
        prog[21] = enc_i(6'h3F, 1, 15, 16'd20);
        prog[22] = enc_r(1, 2, 15, 6'b000000);
        prog[23] = enc_i(6'd43, 5, 8, 16'hFFFC);
        prog[24] = enc_i(6'd4, 0, 0, 16'hFFFF);

        rst = 1'b1;
        for (int i = 0; i < 25; i++) load_word(1'b0, i, prog[i]);
        for (int i = 25; i < 64; i++) load_word(1'b0, i, 32'd0);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'd3);
        load_word(1'b1, 2, 32'hFFFF_FFF0);
        load_word(1'b1, 3, 32'h0000_00FF);
        for (int i = 4; i < 8; i++) load_word(1'b1, i, 32'd0);

        // R1: program present but reset held, nothing executes
        repeat (3) @(negedge clk);
        check("R1 pc in reset", pc_out, 32'd0);
        read_reg(1, v);
        check("R1 no register write in reset", v, 32'd0);

        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 pc after first instruction", pc_out, 32'd4);
        read_reg(1, v);
        check("R3 first load", v, 32'd5);
        @(negedge clk);
        check("R8 pc after second instruction", pc_out, 32'd8);

        repeat (60) @(negedge clk);

        for (int k = 0; k < NEXP; k++) begin
            logic [1:0]  kind;
            logic [7:0]  idx;
            logic [7:0]  rq;
            logic [31:0] ev;
            string       tag;
            {kind, idx, rq, ev} = EXP[k];
            tag = $sformatf("R%0d entry %0d", rq, k);
            if (kind == 2'd0)      read_reg(int'(idx), v);
            else if (kind == 2'd1) read_mem(int'(idx), v);
            else                   v = pc_out;
            check(tag, v, ev);
        end

        // R1: reset in mid-run returns pc to 0 and clears registers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc after mid-run reset", pc_out, 32'd0);
        read_reg(5, v);
        check("R1 register cleared", v, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", pc_out, 32'd96);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule